// File: doc/BRIEF.md
# Frame-Buffered Timeslot Switch Matrix

This block exchanges 8-bit timeslot data between a group of local serial lanes and a group of backplane serial ports. Both sides run at one bit per clock, with `NSLOT` timeslots of 8 bits per frame. Every local input channel (lane, slot) has a destination routing entry. The entry decides which backplane port and timeslot carry that channel's byte, or whether the byte goes onto an internal local-connect bus. Every local output channel has a source routing entry. That entry picks the backplane port and timeslot, or the local-connect bus slot, that the channel takes its byte from. It also decides whether the local output lane is driven in that slot.

Incoming bits are shifted into per-channel holding registers. At the frame boundary the whole set is copied into output registers, so switched data arrives exactly one frame later. Looped local traffic crosses the switch twice and arrives two frames later. A destination channel can send a byte written over a parallel port instead of its serial input. Any source channel's selected byte can be read back in parallel. Routing writes are staged and committed only on timeslot boundaries. Pad tri-state is represented by enable outputs.

Top module: `tsi_switch`

## Requirements
- R1: `fsync` is high in the first bit cycle of every frame and low otherwise. The frame is `NSLOT*8` cycles long, and the first cycle after reset release is bit 0 of slot 0.
- R2: Reset clears all routing entries. Every `lso_oe`/`bso_oe` bit is then low, every `lso`/`bso` line idles at 1, and every destination parallel byte is 0x00.
- R3: Serial bytes travel MSB first: the first bit of a slot is byte bit 7, on input and on output. Parallel bytes use the same mapping.
- R4: A destination entry with enable set and local-connect clear puts the channel's input byte from frame F onto backplane port `port`, slot `ts`, in frame F+1, and raises `bso_oe` there. The entry is laid out as {par, en, lc, port, ts}. With the default parameters ts is bits [2:0], port is bit 3, lc is bit 4, en is bit 5 and par is bit 6. Channel number = lane*NSLOT + slot.
- R5: A source entry with lc clear sends the byte that backplane port `port`, slot `ts`, carried in frame F out on its own local lane and slot in frame F+1.
- R6: When several enabled destination channels target the same backplane port and slot, the port carries the bitwise AND of their bytes.
- R7: A destination entry with lc set places its byte on local-connect slot `ts` instead of the backplane. A source entry with lc set reads local-connect slot `ts`. Input to output then takes two frames, and the backplane is not driven for that entry.
- R8: A destination entry with par set transmits the channel's parallel byte, which `pa_wr` writes immediately, in place of its serial input.
- R9: `pa_rdata` shows the byte that the source entry for channel `pa_raddr` currently selects.
- R10: A routing write is held in a single pending register and takes effect in the slot after the next slot's last bit. A second write issued before that commit replaces the pending one.
- R11: The source entry's en bit drives `lso_oe` for its channel's slot. When en is clear the lane outputs 1. Output enables change only on slot boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lsi | input | NLP | Local serial input lanes |
| lso | output | NLP | Local serial output lanes |
| lso_oe | output | NLP | Local output drive enables |
| bsi | input | NBP | Backplane serial inputs |
| bso | output | NBP | Backplane serial outputs |
| bso_oe | output | NBP | Backplane drive enables |
| fsync | output | 1 | First-bit-of-frame marker |
| rt_wr | input | 1 | Routing write strobe |
| rt_src | input | 1 | 1 selects source table, 0 destination table |
| rt_addr | input | CW | Routing entry channel number |
| rt_data | input | EW | Routing entry value |
| pa_wr | input | 1 | Destination parallel byte write strobe |
| pa_waddr | input | CW | Parallel write channel |
| pa_wdata | input | 8 | Parallel write byte |
| pa_raddr | input | CW | Source parallel read channel |
| pa_rdata | output | 8 | Source parallel read byte |

## Verification
The serial inputs carry a byte pattern that differs per frame, lane and slot. Matching a received byte against frame F rather than F+1 therefore separates a one-frame latency from a zero- or two-frame one, and a wrong channel or a reversed bit order shows up as a mismatch. Two channels routed into one backplane slot with different bytes show AND combining as opposed to either winning alone. Routing writes issued in the middle of a slot, and pairs of writes to different channels before a commit, separate boundary gating from immediate update and show which pending write survives.

// File: rtl/tsi_pkg.sv
// Shared types for the timeslot switch.
package tsi_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/tsi_timing.sv
// Frame timing: counts bits within a slot and slots within a frame.
// Assumes NSLOT is a power of two and at least 2.
module tsi_timing #(
    parameter int NSLOT = 8,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [2:0]    bit_idx,
    output logic [SW-1:0] slot_idx,
    output logic          slot_end,
    output logic          frame_end,
    output logic          fsync
);
    assign slot_end  = (bit_idx == 3'd7);
    assign frame_end = slot_end && (slot_idx == SW'(NSLOT - 1));
    assign fsync     = (bit_idx == 3'd0) && (slot_idx == '0);

    // Advance bit and slot counters, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            slot_idx <= '0;
        end else begin
            bit_idx <= bit_idx + 3'd1;
            if (slot_end) slot_idx <= frame_end ? '0 : slot_idx + SW'(1);
        end
    end
endmodule

// File: rtl/tsi_route_tab.sv
// Routing table with one pending write register. A write is staged and
// committed on the next slot-end cycle; a newer write replaces a staged one.
module tsi_route_tab #(
    parameter int NCH = 16,
    parameter int EW  = 7,
    localparam int CW = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [CW-1:0]           addr,
    input  logic [EW-1:0]           data,
    input  logic                    slot_end,
    output logic [NCH-1:0][EW-1:0]  tab
);
    logic          pend_v;
    logic [CW-1:0] pend_a;
    logic [EW-1:0] pend_d;

    // Stage writes and commit the staged entry at slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab    <= '0;
            pend_v <= 1'b0;
            pend_a <= '0;
            pend_d <= '0;
        end else begin
            if (slot_end && pend_v) tab[pend_a] <= pend_d;
            if (wr) begin
                pend_v <= 1'b1;
                pend_a <= addr;
                pend_d <= data;
            end else if (slot_end) begin
                pend_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tsi_frame_buf.sv
// Serial-to-byte capture with frame double buffering. Each lane shifts MSB
// first; the byte is stored per slot in the holding set, and the holding set
// (including the slot just finishing) moves to the output set at frame end.
module tsi_frame_buf
    import tsi_pkg::*;
#(
    parameter int LANES = 2,
    parameter int NSLOT = 8,
    localparam int SW = $clog2(NSLOT),
    localparam int NB = LANES * NSLOT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LANES-1:0]     din,
    input  logic [SW-1:0]        slot_idx,
    input  logic                 slot_end,
    input  logic                 frame_end,
    output logic [NB-1:0][7:0]   out_q
);
    logic [LANES-1:0][7:0] sh;
    logic [LANES-1:0][7:0] cap;
    logic [NB-1:0][7:0]    hold;

    // Byte completed this cycle on each lane.
    always_comb begin
        for (int l = 0; l < LANES; l++) cap[l] = {sh[l][6:0], din[l]};
    end

    // Shift, hold per slot, and swap at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            hold  <= '0;
            out_q <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) sh[l] <= cap[l];
            if (slot_end) begin
                for (int l = 0; l < LANES; l++) hold[l*NSLOT + int'(slot_idx)] <= cap[l];
            end
            if (frame_end) begin
                for (int c = 0; c < NB; c++)
                    out_q[c] <= (c % NSLOT == NSLOT - 1) ? cap[c / NSLOT] : hold[c];
            end
        end
    end
endmodule

// File: rtl/tsi_switch.sv
// Frame-buffered timeslot switch between local lanes and backplane ports.
// Assumes NSLOT is a power of two. Entry layout {par, en, lc, port, ts}.
// Destination bytes with matching port/slot are ANDed; lines idle at 1.
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NLP   = 2,
    parameter int NBP   = 2,
    parameter int NSLOT = 8,
    localparam int SW  = $clog2(NSLOT),
    localparam int TW  = SW,
    localparam int PW  = (NBP > 1) ? $clog2(NBP) : 1,
    localparam int EW  = TW + PW + 3,
    localparam int NCH = NLP * NSLOT,
    localparam int NBC = NBP * NSLOT,
    localparam int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NLP-1:0] lsi,
    output logic [NLP-1:0] lso,
    output logic [NLP-1:0] lso_oe,
    input  logic [NBP-1:0] bsi,
    output logic [NBP-1:0] bso,
    output logic [NBP-1:0] bso_oe,
    output logic           fsync,
    input  logic           rt_wr,
    input  logic           rt_src,
    input  logic [CW-1:0]  rt_addr,
    input  logic [EW-1:0]  rt_data,
    input  logic           pa_wr,
    input  logic [CW-1:0]  pa_waddr,
    input  logic [7:0]     pa_wdata,
    input  logic [CW-1:0]  pa_raddr,
    output logic [7:0]     pa_rdata
);
    localparam int B_LC  = TW + PW;
    localparam int B_EN  = TW + PW + 1;
    localparam int B_PAR = TW + PW + 2;

    logic [2:0]              bit_idx;
    logic [2:0]              bit_sel;
    logic [SW-1:0]           slot_idx;
    logic                    slot_end;
    logic                    frame_end;
    logic [NCH-1:0][EW-1:0]  dst_tab;
    logic [NCH-1:0][EW-1:0]  src_tab;
    logic [NCH-1:0][7:0]     dst_par;
    logic [NCH-1:0][7:0]     lin_out;
    logic [NBC-1:0][7:0]     bin_out;
    logic [NSLOT-1:0][7:0]   lp_out;
    logic [NCH-1:0]          tx_bit;
    logic [NCH-1:0][7:0]     src_byte;
    logic                    loop_bit;

    tsi_timing #(.NSLOT(NSLOT)) u_tim (
        .clk(clk), .rst_n(rst_n), .bit_idx(bit_idx), .slot_idx(slot_idx),
        .slot_end(slot_end), .frame_end(frame_end), .fsync(fsync)
    );

    tsi_route_tab #(.NCH(NCH), .EW(EW)) u_dst_tab (
        .clk(clk), .rst_n(rst_n), .wr(rt_wr && !rt_src), .addr(rt_addr),
        .data(rt_data), .slot_end(slot_end), .tab(dst_tab)
    );

    tsi_route_tab #(.NCH(NCH), .EW(EW)) u_src_tab (
        .clk(clk), .rst_n(rst_n), .wr(rt_wr && rt_src), .addr(rt_addr),
        .data(rt_data), .slot_end(slot_end), .tab(src_tab)
    );

    tsi_frame_buf #(.LANES(NLP), .NSLOT(NSLOT)) u_lin (
        .clk(clk), .rst_n(rst_n), .din(lsi), .slot_idx(slot_idx),
        .slot_end(slot_end), .frame_end(frame_end), .out_q(lin_out)
    );

    tsi_frame_buf #(.LANES(NBP), .NSLOT(NSLOT)) u_bin (
        .clk(clk), .rst_n(rst_n), .din(bsi), .slot_idx(slot_idx),
        .slot_end(slot_end), .frame_end(frame_end), .out_q(bin_out)
    );

    tsi_frame_buf #(.LANES(1), .NSLOT(NSLOT)) u_loop (
        .clk(clk), .rst_n(rst_n), .din(loop_bit), .slot_idx(slot_idx),
        .slot_end(slot_end), .frame_end(frame_end), .out_q(lp_out)
    );

    assign bit_sel = 3'd7 - bit_idx;

    // Destination parallel bytes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) dst_par <= '0;
        else if (pa_wr) dst_par[pa_waddr] <= pa_wdata;
    end

    // Per destination channel: current transmit bit from serial or parallel byte.
    // Per source channel: byte selected from backplane or local-connect buffer.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [TW-1:0] s_ts;
        logic [PW-1:0] s_pt;
        assign tx_bit[ch] = dst_tab[ch][B_PAR] ? dst_par[ch][bit_sel] : lin_out[ch][bit_sel];
        assign s_ts = src_tab[ch][TW-1:0];
        assign s_pt = src_tab[ch][TW+PW-1:TW];
        assign src_byte[ch] = src_tab[ch][B_LC] ? lp_out[s_ts] :
                              (int'(s_pt) < NBP) ? bin_out[{s_pt, s_ts}] : 8'hFF;
    end

    // Backplane drive: AND of all enabled channels aimed at this port and slot.
    always_comb begin
        for (int p = 0; p < NBP; p++) begin
            bso[p]    = 1'b1;
            bso_oe[p] = 1'b0;
            for (int ch = 0; ch < NCH; ch++) begin
                if (dst_tab[ch][B_EN] && !dst_tab[ch][B_LC] &&
                    dst_tab[ch][TW+PW-1:TW] == PW'(p) && dst_tab[ch][TW-1:0] == slot_idx) begin
                    bso[p]    = bso[p] & tx_bit[ch];
                    bso_oe[p] = 1'b1;
                end
            end
        end
    end

    // Local-connect bus: AND of enabled looped channels aimed at this slot.
    always_comb begin
        loop_bit = 1'b1;
        for (int ch = 0; ch < NCH; ch++) begin
            if (dst_tab[ch][B_EN] && dst_tab[ch][B_LC] && dst_tab[ch][TW-1:0] == slot_idx)
                loop_bit = loop_bit & tx_bit[ch];
        end
    end

    // Local lane outputs from the source entry of the current channel.
    always_comb begin
        for (int lp = 0; lp < NLP; lp++) begin
            logic [CW-1:0] cur;
            cur        = CW'(lp * NSLOT) + CW'(slot_idx);
            lso_oe[lp] = src_tab[cur][B_EN];
            lso[lp]    = src_tab[cur][B_EN] ? src_byte[cur][bit_sel] : 1'b1;
        end
    end

    assign pa_rdata = src_byte[pa_raddr];
endmodule

// File: rtl/tsi_switch_chk.sv
// Protocol checker for tsi_switch, attached by bind.
module tsi_switch_chk #(
    parameter int NLP   = 2,
    parameter int NBP   = 2,
    parameter int NSLOT = 8,
    localparam int SW  = $clog2(NSLOT),
    localparam int PW  = (NBP > 1) ? $clog2(NBP) : 1,
    localparam int EW  = SW + PW + 3,
    localparam int NCH = NLP * NSLOT,
    localparam int FR  = NSLOT * 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   fsync,
    input logic [NLP-1:0]         lso_oe,
    input logic [NBP-1:0]         bso,
    input logic [NBP-1:0]         bso_oe,
    input logic                   slot_end,
    input logic [NCH-1:0][EW-1:0] dst_tab,
    input logic [NCH-1:0][EW-1:0] src_tab
);
    int unsigned cnt;

    // Independent frame position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= 0;
        else cnt <= (cnt == FR - 1) ? 0 : cnt + 1;
    end

    p_frame_marker_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fsync == (cnt == 0));

    p_reset_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lso_oe == '0) && (bso_oe == '0));

    p_commit_on_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(slot_end) |-> $stable(dst_tab) && $stable(src_tab));

    p_oe_slot_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(slot_end) |-> $stable(lso_oe) && $stable(bso_oe));

    p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        &(bso | bso_oe));
endmodule

bind tsi_switch tsi_switch_chk #(.NLP(NLP), .NBP(NBP), .NSLOT(NSLOT)) u_chk (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .lso_oe(lso_oe), .bso(bso),
    .bso_oe(bso_oe), .slot_end(slot_end), .dst_tab(dst_tab), .src_tab(src_tab)
);

// File: tb/tsi_switch_test.sv
`timescale 1ns/1ps
module tsi_switch_test;
    localparam int NLP = 2;
    localparam int NBP = 2;
    localparam int NS  = 8;
    localparam int FR  = NS * 8;
    localparam int CW  = 4;
    localparam int EW  = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NLP-1:0] lsi = '1;
    logic [NLP-1:0] lso, lso_oe;
    logic [NBP-1:0] bsi = '1;
    logic [NBP-1:0] bso, bso_oe;
    logic           fsync;
    logic           rt_wr = 1'b0, rt_src = 1'b0;
    logic [CW-1:0]  rt_addr = '0;
    logic [EW-1:0]  rt_data = '0;
    logic           pa_wr = 1'b0;
    logic [CW-1:0]  pa_waddr = '0, pa_raddr = '0;
    logic [7:0]     pa_wdata = '0;
    logic [7:0]     pa_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int t = 0;
    logic [7:0] got_b   [4][NBP*NS];
    logic       got_boe [4][NBP*NS];
    logic [7:0] got_l   [4][NLP*NS];
    logic       got_loe [4][NLP*NS];
    logic       fs_hist [130];

    tsi_switch uut (
        .clk(clk), .rst_n(rst_n), .lsi(lsi), .lso(lso), .lso_oe(lso_oe),
        .bsi(bsi), .bso(bso), .bso_oe(bso_oe), .fsync(fsync),
        .rt_wr(rt_wr), .rt_src(rt_src), .rt_addr(rt_addr), .rt_data(rt_data),
        .pa_wr(pa_wr), .pa_waddr(pa_waddr), .pa_wdata(pa_wdata),
        .pa_raddr(pa_raddr), .pa_rdata(pa_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] pat_l(int f, int l, int s);
        return 8'((f * 37 + l * 91 + s * 13 + 7) ^ 8'h5A);
    endfunction

    function automatic logic [7:0] pat_b(int f, int p, int s);
        return 8'((f * 53 + p * 29 + s * 71 + 3) ^ 8'hC3);
    endfunction

    // Entry layout {par, en, lc, port, ts[2:0]} (R4)
    function automatic logic [EW-1:0] ent(bit par, bit en, bit lc, bit port, int ts);
        return {par, en, lc, port, 3'(ts)};
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h (t=%0d)", req, got, exp, t);
        end
    endtask

    // One bit cycle: drive serial inputs, record outputs, pass the clock edge.
    task automatic tick();
        int f, s, b;
        logic [7:0] v;
        @(negedge clk);
        f = t / FR; s = (t % FR) / 8; b = t % 8;
        for (int l = 0; l < NLP; l++) begin v = pat_l(f, l, s); lsi[l] = v[7-b]; end
        for (int p = 0; p < NBP; p++) begin v = pat_b(f, p, s); bsi[p] = v[7-b]; end
        #1;
        for (int p = 0; p < NBP; p++) begin
            got_b[f%4][p*NS+s][7-b] = bso[p];
            if (b == 0) got_boe[f%4][p*NS+s] = bso_oe[p];
        end
        for (int l = 0; l < NLP; l++) begin
            got_l[f%4][l*NS+s][7-b] = lso[l];
            if (b == 0) got_loe[f%4][l*NS+s] = lso_oe[l];
        end
        if (t < 130) fs_hist[t] = fsync;
        @(posedge clk); #1;
        t++;
    endtask

    task automatic run_to(int target);
        while (t < target) tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rt_wr = 1'b0; pa_wr = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t = 0;
    endtask

    // Routing write followed by enough cycles to pass one slot boundary.
    task automatic rt_write(bit src, int addr, logic [EW-1:0] d);
        rt_wr = 1'b1; rt_src = src; rt_addr = CW'(addr); rt_data = d;
        tick();
        rt_wr = 1'b0;
        repeat (8) tick();
    endtask

    task automatic test_reset();
        do_reset();
        run_to(FR);
        chk("R1 fsync t0", 8'(fs_hist[0]), 8'd1);
        chk("R1 fsync t1", 8'(fs_hist[1]), 8'd0);
        chk("R1 fsync t63", 8'(fs_hist[63]), 8'd0);
        for (int c = 0; c < NBP*NS; c++) begin
            chk("R2 bso idle", got_b[0][c], 8'hFF);
            chk("R2 bso_oe off", 8'(got_boe[0][c]), 8'd0);
        end
        for (int c = 0; c < NLP*NS; c++) begin
            chk("R2 lso idle", got_l[0][c], 8'hFF);
            chk("R2 lso_oe off", 8'(got_loe[0][c]), 8'd0);
        end
        rt_write(1'b0, 0, ent(1, 1, 0, 0, 2));
        run_to(3*FR);
        chk("R1 fsync t64", 8'(fs_hist[64]), 8'd1);
        chk("R2 parallel byte cleared", got_b[2][2], 8'h00);
    endtask

    task automatic test_dst_route();
        do_reset();
        rt_write(1'b0, 3, ent(0, 1, 0, 1, 5));
        run_to(4*FR);
        for (int f = 1; f <= 2; f++)
            chk("R4 R3 local to backplane", got_b[(f+1)%4][NS+5], pat_l(f, 0, 3));
        chk("R4 oe in routed slot", 8'(got_boe[3][NS+5]), 8'd1);
        chk("R4 oe off elsewhere", 8'(got_boe[3][NS+4]), 8'd0);
    endtask

    task automatic test_src_route();
        do_reset();
        rt_write(1'b1, 10, ent(0, 1, 0, 0, 6));
        run_to(4*FR);
        for (int f = 1; f <= 2; f++)
            chk("R5 R3 backplane to local", got_l[(f+1)%4][10], pat_b(f, 0, 6));
        chk("R11 lso_oe on", 8'(got_loe[3][10]), 8'd1);
        chk("R11 lso_oe off", 8'(got_loe[3][11]), 8'd0);
        chk("R11 lso idle high", got_l[3][11], 8'hFF);
        pa_raddr = 4'd10;
        run_to(4*FR + 20);
        chk("R9 source parallel read", pa_rdata, pat_b(3, 0, 6));
    endtask

    task automatic test_and();
        do_reset();
        rt_write(1'b0, 0, ent(0, 1, 0, 0, 1));
        rt_write(1'b0, 8, ent(0, 1, 0, 0, 1));
        run_to(4*FR);
        chk("R6 AND combine", got_b[3][1], pat_l(2, 0, 0) & pat_l(2, 1, 0));
    endtask

    task automatic test_loop();
        do_reset();
        rt_write(1'b0, 5, ent(0, 1, 1, 0, 4));
        rt_write(1'b1, 12, ent(0, 1, 1, 0, 4));
        run_to(5*FR);
        for (int f = 1; f <= 2; f++)
            chk("R7 two-frame loop", got_l[(f+2)%4][12], pat_l(f, 0, 5));
        chk("R7 no backplane drive", 8'(got_boe[0][4]), 8'd0);
    endtask

    task automatic test_par();
        do_reset();
        rt_write(1'b0, 6, ent(1, 1, 0, 0, 7));
        pa_wr = 1'b1; pa_waddr = 4'd6; pa_wdata = 8'hA5;
        tick();
        pa_wr = 1'b0;
        run_to(3*FR);
        chk("R8 parallel transmit", got_b[2][7], 8'hA5);
        pa_wr = 1'b1; pa_wdata = 8'h3C;
        tick();
        pa_wr = 1'b0;
        run_to(4*FR);
        chk("R8 parallel rewrite", got_b[3][7], 8'h3C);
    endtask

    task automatic test_gate();
        do_reset();
        rt_write(1'b0, 3, ent(0, 1, 0, 1, 5));
        run_to(FR + 5*8 + 2);
        rt_wr = 1'b1; rt_src = 1'b0; rt_addr = 4'd3; rt_data = '0;
        tick();
        rt_wr = 1'b0;
        run_to(FR + 5*8 + 6);
        chk("R10 mid-slot write not applied", 8'(bso_oe[1]), 8'd1);
        run_to(3*FR);
        chk("R10 write applied next frame", 8'(got_boe[2][NS+5]), 8'd0);
        rt_wr = 1'b1; rt_addr = 4'd7; rt_data = ent(0, 1, 0, 1, 2);
        tick();
        rt_addr = 4'd1; rt_data = ent(0, 1, 0, 1, 3);
        tick();
        rt_wr = 1'b0;
        run_to(5*FR);
        chk("R10 replaced write dropped", 8'(got_boe[0][NS+2]), 8'd0);
        chk("R10 latest write kept", 8'(got_boe[0][NS+3]), 8'd1);
    endtask

    initial begin
        #4000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        test_reset();
        test_dst_route();
        test_src_route();
        test_and();
        test_loop();
        test_par();
        test_gate();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule